// File: doc/BRIEF.md
# Flash Block-Lock Scan and Unlock Controller

This controller sits on the host side of a byte-wide parallel flash bus and works out whether any erase block of the device is write-protected. On a start pulse it clears the device status and switches the device into identifier mode. It then reads the global lockdown byte and walks the block layout, reading the lock configuration byte of each block. After the walk it returns the device to array mode. If at least one block is locked and global lockdown is off, it issues the clear-all-locks command pair, returns to array mode and polls the status byte until the device reports ready.

The block walk supports two layouts, chosen by a static input. The uniform layout has 64 KiB blocks throughout. The boot layout has 8 KiB blocks across the first 64 KiB and 64 KiB blocks above that. The device size is also a static input. When the walk ends the controller raises `done` and reports two flags: whether any block was found locked, and whether locks were found that could not be cleared because global lockdown is active.

Top module: `lockscan_ctrl`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, `busy`, `done`, `any_locked`, `lock_err`, `bus_we` and `bus_re` are all 0.
- R2: A start pulse while idle produces a write of 0x50 to address 0 in the next cycle, then a write of 0x90 to address 0 in the cycle after. Every bus operation lasts exactly one cycle.
- R3: After 0x90, the controller reads address 3 (the lockdown byte). Read data is taken from `bus_rdata` in the cycle after `bus_re`, and a nonzero byte means lockdown is active.
- R4: With `boot_layout`=0, lock bytes are read at block base + 2, with bases 0, 64 KiB, 128 KiB and so on, in ascending order. Offsets that are not block bases are never read.
- R5: With `boot_layout`=1, the bases below 64 KiB step by 8 KiB (0, 8 KiB, ..., 56 KiB), and from 64 KiB upward they step by 64 KiB.
- R6: The walk ends after the block whose next base would be at or above `dev_size` (in bytes). No read address is at or above `dev_size`.
- R7: After the last lock read, the controller writes 0xFF to address 0.
- R8: If some lock byte was nonzero and the lockdown byte was zero, the 0xFF write is followed by these writes to address 0: 0x60, 0xD0, 0xFF, 0x70. The controller then reads address 0 repeatedly until bit 7 of the returned byte is 1, writes 0xFF to address 0, and raises `done`.
- R9: If every lock byte was zero, the controller raises `done` in the cycle after the 0xFF write, with `any_locked`=0 and `lock_err`=0, and it issues no unlock command.
- R10: If some lock byte was nonzero and the lockdown byte was nonzero, the controller raises `done` in the cycle after the 0xFF write, with `lock_err`=1, and it issues no 0x60 write.
- R11: `done` and the flags hold until the next start pulse taken while idle. A start pulse while `busy` is ignored.
- R12: `any_locked` is 1 exactly when at least one lock byte read during the walk was nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| boot_layout | input | 1 | Static: 1 selects 8 KiB blocks below 64 KiB |
| dev_size | input | ADDR_W+1 | Static: device size in bytes |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | 8 | Command byte written to flash |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until next start |
| any_locked | output | 1 | At least one block lock byte was nonzero |
| lock_err | output | 1 | Locks present but lockdown blocks unlocking |

## Verification
The first bus operation appears in the cycle after the edge that takes `start`. Each later operation follows one cycle after the previous one, except that each read adds one capture cycle before the next operation. `done` rises in the cycle after the final 0xFF write. The bench builds the full expected operation list from the requirements before each start and pushes it into a queue. A monitor samples the strobes at every falling edge and pops one entry for each operation it sees, so any missing, extra or reordered operation shows up at that exact cycle. The flags are compared at the falling edge after `done` rises. At that point the queue must be empty.

// File: rtl/lockscan_pkg.sv
// Shared types and command codes for the block-lock scan controller.
// Assumes a byte-wide flash that decodes these command bytes.
package lockscan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR,
        ST_IDENT,
        ST_MRD,
        ST_MCAP,
        ST_BRD,
        ST_BCAP,
        ST_RST,
        ST_UL_SETUP,
        ST_UL_CONF,
        ST_UL_EXIT,
        ST_SREQ,
        ST_SPOLL,
        ST_SCHK,
        ST_SEXIT
    } seq_state_e;

    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_READ_ID     = 8'h90;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;

    localparam int MASTER_OFS = 3;
    localparam int LOCK_OFS   = 2;
    localparam int READY_BIT  = 7;

endpackage

// File: rtl/lockscan_walker.sv
// Block base address walker.
// Holds the current block base. The step is BOOT_STEP below BOOT_SPAN when
// the boot layout is selected, and MAIN_STEP otherwise. `last` is high when
// the next base would reach dev_size. Assumes dev_size is static during a run.
module lockscan_walker #(
    parameter int ADDR_W    = 21,
    parameter int BOOT_STEP = 8192,
    parameter int MAIN_STEP = 65536,
    parameter int BOOT_SPAN = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic              boot_layout,
    input  logic [ADDR_W:0]   dev_size,
    output logic [ADDR_W-1:0] base,
    output logic              last
);
    localparam int SW = ADDR_W + 1;

    logic [SW-1:0] base_q;
    logic [SW-1:0] step;
    logic [SW-1:0] next_base;

    // Pick the step size for the block at the current base.
    always_comb begin
        if (boot_layout && (base_q < SW'(BOOT_SPAN)))
            step = SW'(BOOT_STEP);
        else
            step = SW'(MAIN_STEP);
        next_base = base_q + step;
        last      = (next_base >= dev_size);
    end

    // Base register: cleared on restart, stepped on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (restart)
            base_q <= '0;
        else if (advance)
            base_q <= next_base;
    end

    assign base = base_q[ADDR_W-1:0];

endmodule

// File: rtl/lockscan_seq.sv
// Sequencer for the scan, the unlock decision and the status wait.
// Assumes read data arrives one cycle after a read state. The result flags
// are registered and hold until the next accepted start.
module lockscan_seq
    import lockscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       blk_last,
    input  logic [7:0] bus_rdata,
    output seq_state_e state,
    output logic       walk_restart,
    output logic       walk_advance,
    output logic       busy,
    output logic       done,
    output logic       any_locked,
    output logic       lock_err
);
    seq_state_e state_q;
    logic       master_q;
    logic       any_q;
    logic       done_q;
    logic       err_q;

    // Walker controls derived from the current state.
    always_comb begin
        walk_restart = (state_q == ST_IDLE) && start;
        walk_advance = (state_q == ST_BCAP) && !blk_last;
    end

    // State transitions and result flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            master_q <= 1'b0;
            any_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q  <= ST_CLR;
                    master_q <= 1'b0;
                    any_q    <= 1'b0;
                    done_q   <= 1'b0;
                    err_q    <= 1'b0;
                end
                ST_CLR:   state_q <= ST_IDENT;
                ST_IDENT: state_q <= ST_MRD;
                ST_MRD:   state_q <= ST_MCAP;
                ST_MCAP: begin
                    master_q <= (bus_rdata != 8'h00);
                    state_q  <= ST_BRD;
                end
                ST_BRD:   state_q <= ST_BCAP;
                ST_BCAP: begin
                    if (bus_rdata != 8'h00)
                        any_q <= 1'b1;
                    state_q <= blk_last ? ST_RST : ST_BRD;
                end
                ST_RST: begin
                    if (any_q && !master_q) begin
                        state_q <= ST_UL_SETUP;
                    end else begin
                        done_q  <= 1'b1;
                        err_q   <= any_q;
                        state_q <= ST_IDLE;
                    end
                end
                ST_UL_SETUP: state_q <= ST_UL_CONF;
                ST_UL_CONF:  state_q <= ST_UL_EXIT;
                ST_UL_EXIT:  state_q <= ST_SREQ;
                ST_SREQ:     state_q <= ST_SPOLL;
                ST_SPOLL:    state_q <= ST_SCHK;
                ST_SCHK:     state_q <= bus_rdata[READY_BIT] ? ST_SEXIT : ST_SPOLL;
                ST_SEXIT: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    assign state      = state_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign any_locked = any_q;
    assign lock_err   = err_q;

endmodule

// File: rtl/lockscan_bus.sv
// Bus decode: turns the sequencer state and block base into one-cycle
// read and write strobes with address and command byte. Purely combinational.
module lockscan_bus
    import lockscan_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re
);
    // Map each state to its bus operation.
    always_comb begin
        bus_addr  = '0;
        bus_wdata = 8'h00;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        unique case (state)
            ST_CLR:      begin bus_we = 1'b1; bus_wdata = CMD_CLR_STATUS;  end
            ST_IDENT:    begin bus_we = 1'b1; bus_wdata = CMD_READ_ID;     end
            ST_MRD:      begin bus_re = 1'b1; bus_addr = ADDR_W'(MASTER_OFS); end
            ST_BRD:      begin bus_re = 1'b1; bus_addr = base + ADDR_W'(LOCK_OFS); end
            ST_RST:      begin bus_we = 1'b1; bus_wdata = CMD_READ_ARRAY;  end
            ST_UL_SETUP: begin bus_we = 1'b1; bus_wdata = CMD_LOCK_SETUP;  end
            ST_UL_CONF:  begin bus_we = 1'b1; bus_wdata = CMD_CONFIRM;     end
            ST_UL_EXIT:  begin bus_we = 1'b1; bus_wdata = CMD_READ_ARRAY;  end
            ST_SREQ:     begin bus_we = 1'b1; bus_wdata = CMD_READ_STATUS; end
            ST_SPOLL:    begin bus_re = 1'b1; end
            ST_SEXIT:    begin bus_we = 1'b1; bus_wdata = CMD_READ_ARRAY;  end
            default:     ;
        endcase
    end

endmodule

// File: rtl/lockscan_ctrl.sv
// Top of the block-lock scan and unlock controller.
// Connects the walker, sequencer and bus decode. Assumes boot_layout and
// dev_size stay constant while busy.
module lockscan_ctrl
    import lockscan_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int BOOT_STEP = 8192,
    parameter int MAIN_STEP = 65536,
    parameter int BOOT_SPAN = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              boot_layout,
    input  logic [ADDR_W:0]   dev_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              any_locked,
    output logic              lock_err
);
    seq_state_e        state;
    logic              walk_restart;
    logic              walk_advance;
    logic              blk_last;
    logic [ADDR_W-1:0] blk_base;

    lockscan_walker #(
        .ADDR_W   (ADDR_W),
        .BOOT_STEP(BOOT_STEP),
        .MAIN_STEP(MAIN_STEP),
        .BOOT_SPAN(BOOT_SPAN)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (walk_restart),
        .advance    (walk_advance),
        .boot_layout(boot_layout),
        .dev_size   (dev_size),
        .base       (blk_base),
        .last       (blk_last)
    );

    lockscan_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .blk_last    (blk_last),
        .bus_rdata   (bus_rdata),
        .state       (state),
        .walk_restart(walk_restart),
        .walk_advance(walk_advance),
        .busy        (busy),
        .done        (done),
        .any_locked  (any_locked),
        .lock_err    (lock_err)
    );

    lockscan_bus #(.ADDR_W(ADDR_W)) u_bus (
        .state    (state),
        .base     (blk_base),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re)
    );

endmodule

// File: rtl/lockscan_ctrl_chk.sv
// Checker for lockscan_ctrl. It watches only the ports and keeps one flag:
// whether an unlock setup write has been seen since the last accepted start.
module lockscan_ctrl_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W:0]   dev_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic              busy,
    input logic              done,
    input logic              any_locked,
    input logic              lock_err
);
    logic saw_unlock;

    // Track unlock setup writes within the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            saw_unlock <= 1'b0;
        else if (start && !busy)
            saw_unlock <= 1'b0;
        else if (bus_we && bus_wdata == 8'h60)
            saw_unlock <= 1'b1;
    end

    // R2: the first cycle of a run is the status clear write at address 0
    assert_first_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_we && bus_wdata == 8'h50 && bus_addr == '0));

    // R6: no read reaches past the device end
    assert_read_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> ({1'b0, bus_addr} < dev_size));

    // R4: lock reads land at offset 2 of an aligned block
    assert_lock_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr != ADDR_W'(3) && bus_addr != '0) |-> (bus_addr[1:0] == 2'd2));

    // R10: an error finish never follows an unlock setup write
    assert_no_unlock_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && lock_err) |-> !saw_unlock);

    // R10: the error flag is only raised when locks were seen
    assert_err_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lock_err) |-> any_locked);

    // R9: a clean scan finishes without an unlock setup write
    assert_no_unlock_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !any_locked) |-> !saw_unlock);

    // R11: done is only shown while idle
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind lockscan_ctrl lockscan_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dev_size  (dev_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .busy      (busy),
    .done      (done),
    .any_locked(any_locked),
    .lock_err  (lock_err)
);

// File: tb/test_lockscan_ctrl.sv
// Scoreboard bench: the driver pushes the expected bus operations and the
// monitor pops and compares them at each falling edge.
module test_lockscan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 21;
    localparam int KB         = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              boot_layout = 1'b0;
    logic [ADDR_W:0]   dev_size = 22'(256 * KB);
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_we;
    logic              bus_re;
    logic [7:0]        bus_rdata = 8'h00;
    logic              busy, done, any_locked, lock_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // expected op: {is_write, addr, data}
    logic [29:0] exp_q[$];

    // flash model state
    logic [7:0] lock_mem [0:255];
    logic [7:0] master_byte = 8'h00;
    int         busy_polls = 0;

    lockscan_ctrl #(.ADDR_W(ADDR_W)) i_lockscan_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .boot_layout(boot_layout),
        .dev_size(dev_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .any_locked(any_locked), .lock_err(lock_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Flash model: registered reads, status busy for two polls after 0x70.
    always @(posedge clk) begin
        if (bus_re) begin
            if (bus_addr == 21'd3)
                bus_rdata <= master_byte;
            else if (bus_addr == 21'd0) begin
                bus_rdata <= (busy_polls > 0) ? 8'h00 : 8'h80;
                if (busy_polls > 0) busy_polls <= busy_polls - 1;
            end else
                bus_rdata <= lock_mem[bus_addr[20:13]];
        end
        if (bus_we && bus_wdata == 8'h70)
            busy_polls <= 2;
    end

    // Monitor: pop and compare one expected op per observed strobe.
    always @(negedge clk) begin
        if (rst_n && (bus_we || bus_re)) begin
            logic [29:0] e;
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected bus op", {bus_we, bus_addr, bus_wdata}, 0);
            end else begin
                e = exp_q.pop_front();
                check(e[29] == bus_we, "R2", "op kind", 32'(bus_we), 32'(e[29]));
                check(e[28:8] == bus_addr, e[29] ? "R8" : "R4", "op addr",
                      32'(bus_addr), 32'(e[28:8]));
                if (bus_we)
                    check(e[7:0] == bus_wdata, "R7", "write data",
                          32'(bus_wdata), 32'(e[7:0]));
            end
        end
    end

    task automatic push_op(input bit w, input int addr, input logic [7:0] d);
        exp_q.push_back({w, 21'(addr), d});
    endtask

    // Driver: build the expected operation list from the requirements,
    // then start the run and compare the flags after done.
    task automatic run_case(input string name, input bit boot, input int size,
                            input logic [7:0] master, input int lock_idx,
                            input bit poke_busy);
        bit exp_any = 0;
        bit unlock;
        for (int i = 0; i < 256; i++) lock_mem[i] = 8'h00;
        if (lock_idx >= 0) lock_mem[lock_idx] = 8'h01;
        master_byte = master;
        boot_layout = boot;
        dev_size    = 22'(size);
        push_op(1, 0, 8'h50);                           // R2
        push_op(1, 0, 8'h90);                           // R2
        push_op(0, 3, 8'h00);                           // R3
        for (int b = 0; b < size; b += ((boot && b < 64 * KB) ? 8 * KB : 64 * KB)) begin
            push_op(0, b + 2, 8'h00);                   // R4 R5 R6
            if (lock_mem[b / (8 * KB)] != 0) exp_any = 1;
        end
        push_op(1, 0, 8'hFF);                           // R7
        unlock = exp_any && (master == 0);
        if (unlock) begin                               // R8
            push_op(1, 0, 8'h60);
            push_op(1, 0, 8'hD0);
            push_op(1, 0, 8'hFF);
            push_op(1, 0, 8'h70);
            push_op(0, 0, 8'h00);
            push_op(0, 0, 8'h00);
            push_op(0, 0, 8'h00);
            push_op(1, 0, 8'hFF);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke_busy) begin                            // R11: start while busy
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R6", {name, " ops left"}, 32'(exp_q.size()), 0);
        check(any_locked == exp_any, "R12", {name, " any_locked"},
              32'(any_locked), 32'(exp_any));
        check(lock_err == (exp_any && master != 0), "R10", {name, " lock_err"},
              32'(lock_err), 32'(exp_any && master != 0));
        if (!exp_any)
            check(!lock_err && !any_locked, "R9", {name, " clean flags"},
                  {lock_err, any_locked}, 0);
        repeat (3) @(negedge clk);
        check(done && !busy, "R11", {name, " done held"}, {done, busy}, 32'h2);
        check(!bus_we && !bus_re, "R11", {name, " quiet after done"},
              {bus_we, bus_re}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) lock_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !any_locked && !lock_err && !bus_we && !bus_re,
              "R1", "outputs in reset",
              {busy, done, any_locked, lock_err, bus_we, bus_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_we && !bus_re, "R1", "idle after reset",
              {busy, done, bus_we, bus_re}, 0);

        // R9 R4: uniform layout, nothing locked
        run_case("uniform clean", 0, 256 * KB, 8'h00, -1, 0);
        // R8 R11: uniform, block at 128 KiB locked, lockdown off, start poked while busy
        run_case("uniform unlock", 0, 256 * KB, 8'h00, 16, 1);
        // R5 R10: boot layout, 8 KiB block locked, lockdown on
        run_case("boot lockdown", 1, 256 * KB, 8'h01, 1, 0);
        // R5 R8: boot layout, top block locked, lockdown off
        run_case("boot unlock", 1, 256 * KB, 8'h00, 24, 0);
        // R4 R6: uniform 128 KiB, lock byte at 8 KiB is not a block base
        run_case("uniform non-base", 0, 128 * KB, 8'h00, 1, 0);
        // R6 R5: boot layout, device only 64 KiB
        run_case("boot small", 1, 64 * KB, 8'h00, 7, 0);
        // R10: lockdown byte set but nothing locked -> no error
        run_case("lockdown clean", 0, 128 * KB, 8'h80, -1, 0);
        report();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

endmodule